// File: doc/BRIEF.md
# Configurable 16-bit CPU Register Bridge

This block sits between a 16-bit CPU bus driven from outside the core clock domain and an internal file of byte-wide registers. Each CPU access names one halfword, and that halfword holds two byte registers: the even one (internal byte address 2*N) and the odd one (2*N+1). Reads return both bytes at once. Writes can update either byte, or both.

A mode register sets how a halfword is laid out on the bus and how writes are marked. With the byte-order flag clear (little-endian), the even register travels on bits [7:0] and the odd register on bits [15:8]. With the flag set (big-endian), the lanes swap. The bus-mode flag chooses one of two write schemes. In dual-strobe mode, each lane has its own active-low write strobe. In byte-enable mode, one active-low write strobe is qualified by two active-low lane enables. The mode register sits at halfword 0 in every mapping, so software can reach it from any state. Software is expected to program it right after reset.

All control, address and data inputs pass through a two-flop synchronizer. A write is committed when the relevant strobe rises. The data, address and enables used are the ones sampled in the core cycle before the strobe was seen high.

Top module: `cpu_reg_bridge`

## Requirements
- R1: After reset every byte register reads as 0x00, and the mode register is 0: little-endian, dual-strobe.
- R2: In little-endian mode, the even register of a halfword is read and written on bits [7:0] and the odd register on bits [15:8].
- R3: In big-endian mode, the even register is on bits [15:8] and the odd register is on bits [7:0].
- R4: In dual-strobe mode, a rising edge of the high strobe writes only the byte on bits [15:8]. A rising edge of the low strobe writes only the byte on bits [7:0]. Both strobes may be used together.
- R5: In byte-enable mode, a rising edge of the single write strobe writes exactly the lanes whose enable was low. The high enable covers [15:8] and the low enable covers [7:0].
- R6: The write strobes of the inactive scheme are ignored. The single strobe has no effect in dual-strobe mode, and the two lane strobes have no effect in byte-enable mode.
- R7: A byte-enable write with both enables high changes no register.
- R8: A write made while chip select is high changes no register.
- R9: The mode register is halfword 0 and is written from the low lane only: bit 0 selects big-endian and bit 1 selects byte-enable mode. It reads back as {14'b0, bit1, bit0} on bits [15:0] under every mapping. Halfword 0 holds no byte registers.
- R10: Read data and its output enable are driven only while chip select and read strobe are both low, two core cycles after they are sampled. Otherwise the read data is 0x0000 and the enable is low.
- R11: A mode change is applied from the next access on. The write to the mode register is itself decoded with the old mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | HW_W | Halfword address |
| cpu_cs_n | input | 1 | Chip select, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wrh_n | input | 1 | High-lane write strobe (dual-strobe mode), active low |
| cpu_wrl_n | input | 1 | Low-lane write strobe (dual-strobe mode), active low |
| cpu_wr_n | input | 1 | Single write strobe (byte-enable mode), active low |
| cpu_beh_n | input | 1 | High-lane enable (byte-enable mode), active low |
| cpu_bel_n | input | 1 | Low-lane enable (byte-enable mode), active low |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, zero when not reading |
| cpu_rdata_oe | output | 1 | Read data valid / bus drive enable |

## Verification
Read data follows the synchronized chip select, read strobe and address. It is valid after the second core edge that samples them. The bench therefore holds every read for four core cycles and samples on the falling edge that follows.

A write lands on the third core edge after its strobe rises. This is two synchronizer stages plus the delayed copy used to detect the edge. The bench keeps chip select low for one more cycle and idles four cycles before the next access, so every read-back sees the committed value.

The checker ties each commit to strobe and select levels three cycles earlier, which is the same pipeline depth.

// File: rtl/cpu_bridge_pkg.sv
// Package: shared widths and types for the CPU register bridge.
// Assumes a fixed 16-bit external bus split into two 8-bit lanes.
package cpu_bridge_pkg;
    localparam int BYTE_W = 8;
    localparam int BUS_W  = 2 * BYTE_W;

    // Mode register contents; big_endian is bit 0, be_mode is bit 1.
    typedef struct packed {
        logic be_mode;
        logic big_endian;
    } mode_t;

    // Synchronized CPU control pins, all active low.
    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wrh_n;
        logic wrl_n;
        logic wr_n;
        logic beh_n;
        logic bel_n;
    } cpu_ctl_t;

    localparam int CTL_W = $bits(cpu_ctl_t);
endpackage

// File: rtl/bus_sync.sv
// Module: bus_sync
// Two-flop synchronizer for a vector of CPU pins, plus one extra delayed
// copy so that edges of the synchronized value can be detected.
// Assumes multi-bit fields are held stable by the CPU while they are sampled.
module bus_sync #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_now,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [W-1:0] stage3;

    // Shift the asynchronous inputs through three core-clock registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
            stage3 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign q_now  = stage2;
    assign q_prev = stage3;
endmodule

// File: rtl/write_decode.sv
// Module: write_decode
// Turns synchronized strobe edges into per-byte write pulses, using the
// current mode for lane qualification and lane-to-register mapping.
// Assumes the delayed sample holds the address, data and enables that were
// valid while the strobe was still low.
module write_decode
    import cpu_bridge_pkg::*;
#(
    parameter int HW_W = 4
) (
    input  cpu_bridge_pkg::mode_t mode,
    input  logic              cs_prev_n,
    input  logic              wrh_now_n,
    input  logic              wrh_prev_n,
    input  logic              wrl_now_n,
    input  logic              wrl_prev_n,
    input  logic              wr_now_n,
    input  logic              wr_prev_n,
    input  logic              beh_prev_n,
    input  logic              bel_prev_n,
    input  logic [HW_W-1:0]   hw_prev,
    input  logic [BUS_W-1:0]  data_prev,
    output logic              wr_even,
    output logic              wr_odd,
    output logic [BYTE_W-1:0] even_byte,
    output logic [BYTE_W-1:0] odd_byte,
    output logic              mode_wr,
    output cpu_bridge_pkg::mode_t mode_next
);
    logic hi_rise;
    logic lo_rise;
    logic wr_rise;
    logic hi_go;
    logic lo_go;
    logic is_mode_hw;

    // Detect rising strobe edges within a selected access.
    always_comb begin
        hi_rise = !cs_prev_n && !wrh_prev_n && wrh_now_n;
        lo_rise = !cs_prev_n && !wrl_prev_n && wrl_now_n;
        wr_rise = !cs_prev_n && !wr_prev_n  && wr_now_n;
    end

    // Pick the active lane-qualification scheme.
    always_comb begin
        if (mode.be_mode) begin
            hi_go = wr_rise && !beh_prev_n;
            lo_go = wr_rise && !bel_prev_n;
        end else begin
            hi_go = hi_rise;
            lo_go = lo_rise;
        end
    end

    // Map lanes onto the even/odd registers and route the mode write.
    always_comb begin
        is_mode_hw = (hw_prev == '0);
        mode_wr    = lo_go && is_mode_hw;
        mode_next  = mode_t'(data_prev[1:0]);
        if (mode.big_endian) begin
            wr_even   = hi_go && !is_mode_hw;
            wr_odd    = lo_go && !is_mode_hw;
            even_byte = data_prev[BUS_W-1:BYTE_W];
            odd_byte  = data_prev[BYTE_W-1:0];
        end else begin
            wr_even   = lo_go && !is_mode_hw;
            wr_odd    = hi_go && !is_mode_hw;
            even_byte = data_prev[BYTE_W-1:0];
            odd_byte  = data_prev[BUS_W-1:BYTE_W];
        end
    end
endmodule

// File: rtl/byte_reg_file.sv
// Module: byte_reg_file
// Array of byte registers organised as even/odd pairs per halfword.
// Halfword 0 is reserved for the mode register and stores nothing here.
// Assumes at most one halfword is addressed per write cycle.
module byte_reg_file
    import cpu_bridge_pkg::*;
#(
    parameter int HW_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_even,
    input  logic                        wr_odd,
    input  logic [HW_W-1:0]             wr_hw,
    input  logic [BYTE_W-1:0]           even_byte,
    input  logic [BYTE_W-1:0]           odd_byte,
    input  logic [HW_W-1:0]             rd_hw,
    output logic [BYTE_W-1:0]           rd_even,
    output logic [BYTE_W-1:0]           rd_odd,
    output logic [(1<<HW_W)*BUS_W-1:0]  file_flat
);
    localparam int NUM_HW = 1 << HW_W;

    for (genvar h = 0; h < NUM_HW; h++) begin : g_hw
        if (h == 0) begin : g_reserved
            assign file_flat[h*BUS_W +: BUS_W] = '0;
        end else begin : g_store
            logic [BYTE_W-1:0] even_q;
            logic [BYTE_W-1:0] odd_q;
            logic              hit;

            assign hit = (wr_hw == HW_W'(h));

            // Hold the even and odd bytes of this halfword.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    even_q <= '0;
                    odd_q  <= '0;
                end else begin
                    if (wr_even && hit) even_q <= even_byte;
                    if (wr_odd && hit)  odd_q  <= odd_byte;
                end
            end

            assign file_flat[h*BUS_W +: BUS_W] = {odd_q, even_q};
        end
    end

    // Select the addressed halfword for reading.
    always_comb begin
        rd_even = file_flat[rd_hw*BUS_W +: BYTE_W];
        rd_odd  = file_flat[rd_hw*BUS_W + BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/read_path.sv
// Module: read_path
// Builds the 16-bit read word for the current mapping and gates it with
// the synchronized chip select and read strobe.
// Assumes halfword 0 is the mode register under every mapping.
module read_path
    import cpu_bridge_pkg::*;
#(
    parameter int HW_W = 4
) (
    input  cpu_bridge_pkg::mode_t mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [HW_W-1:0]   rd_hw,
    input  logic [BYTE_W-1:0] rd_even,
    input  logic [BYTE_W-1:0] rd_odd,
    output logic [BUS_W-1:0]  rdata,
    output logic              rdata_oe
);
    logic [BUS_W-1:0] word;

    // Arrange the bytes by endian setting, or expose the mode register.
    always_comb begin
        if (rd_hw == '0)
            word = {{(BUS_W-2){1'b0}}, mode};
        else if (mode.big_endian)
            word = {rd_even, rd_odd};
        else
            word = {rd_odd, rd_even};
    end

    // Drive data only during a selected read.
    always_comb begin
        rdata_oe = !cs_n && !rd_n;
        rdata    = rdata_oe ? word : '0;
    end
endmodule

// File: rtl/cpu_reg_bridge.sv
// Module: cpu_reg_bridge (top)
// Bridges a 16-bit CPU bus onto byte registers with selectable byte order
// and selectable write signalling (dual strobe or strobe plus enables).
// Assumes the CPU holds address/data stable around strobe edges for at
// least three core cycles.
module cpu_reg_bridge
    import cpu_bridge_pkg::*;
#(
    parameter int HW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HW_W-1:0]   cpu_addr,
    input  logic              cpu_cs_n,
    input  logic              cpu_rd_n,
    input  logic              cpu_wrh_n,
    input  logic              cpu_wrl_n,
    input  logic              cpu_wr_n,
    input  logic              cpu_beh_n,
    input  logic              cpu_bel_n,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    output logic              cpu_rdata_oe
);
    localparam int AD_W   = HW_W + BUS_W;
    localparam int NUM_HW = 1 << HW_W;

    cpu_ctl_t          ctl_now, ctl_prev;
    logic [CTL_W-1:0]  ctl_now_v, ctl_prev_v;
    logic [AD_W-1:0]   ad_now, ad_prev;
    mode_t             mode_q, mode_next;
    logic              wr_even, wr_odd, mode_wr;
    logic [BYTE_W-1:0] even_byte, odd_byte, rd_even, rd_odd;
    logic [NUM_HW*BUS_W-1:0] file_flat;

    bus_sync #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cpu_cs_n, cpu_rd_n, cpu_wrh_n, cpu_wrl_n,
                   cpu_wr_n, cpu_beh_n, cpu_bel_n}),
        .q_now   (ctl_now_v),
        .q_prev  (ctl_prev_v)
    );

    bus_sync #(.W(AD_W), .RST_VAL('0)) u_ad_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cpu_addr, cpu_wdata}),
        .q_now   (ad_now),
        .q_prev  (ad_prev)
    );

    assign ctl_now  = cpu_ctl_t'(ctl_now_v);
    assign ctl_prev = cpu_ctl_t'(ctl_prev_v);

    write_decode #(.HW_W(HW_W)) u_wdec (
        .mode       (mode_q),
        .cs_prev_n  (ctl_prev.cs_n),
        .wrh_now_n  (ctl_now.wrh_n),
        .wrh_prev_n (ctl_prev.wrh_n),
        .wrl_now_n  (ctl_now.wrl_n),
        .wrl_prev_n (ctl_prev.wrl_n),
        .wr_now_n   (ctl_now.wr_n),
        .wr_prev_n  (ctl_prev.wr_n),
        .beh_prev_n (ctl_prev.beh_n),
        .bel_prev_n (ctl_prev.bel_n),
        .hw_prev    (ad_prev[AD_W-1:BUS_W]),
        .data_prev  (ad_prev[BUS_W-1:0]),
        .wr_even    (wr_even),
        .wr_odd     (wr_odd),
        .even_byte  (even_byte),
        .odd_byte   (odd_byte),
        .mode_wr    (mode_wr),
        .mode_next  (mode_next)
    );

    // Hold the mapping and bus-mode settings.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= mode_next;
    end

    byte_reg_file #(.HW_W(HW_W)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_even   (wr_even),
        .wr_odd    (wr_odd),
        .wr_hw     (ad_prev[AD_W-1:BUS_W]),
        .even_byte (even_byte),
        .odd_byte  (odd_byte),
        .rd_hw     (ad_now[AD_W-1:BUS_W]),
        .rd_even   (rd_even),
        .rd_odd    (rd_odd),
        .file_flat (file_flat)
    );

    read_path #(.HW_W(HW_W)) u_rd (
        .mode     (mode_q),
        .cs_n     (ctl_now.cs_n),
        .rd_n     (ctl_now.rd_n),
        .rd_hw    (ad_now[AD_W-1:BUS_W]),
        .rd_even  (rd_even),
        .rd_odd   (rd_odd),
        .rdata    (cpu_rdata),
        .rdata_oe (cpu_rdata_oe)
    );
endmodule

// File: rtl/bridge_checker.sv
// Module: bridge_checker
// Protocol and state-hold properties for cpu_reg_bridge, bound to the top.
// Assumes the two-flop synchronizer plus edge stage gives a 3-cycle depth.
module bridge_checker #(
    parameter int HW_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cpu_cs_n,
    input logic                       cpu_rd_n,
    input logic                       cpu_wrh_n,
    input logic                       cpu_wrl_n,
    input logic                       cpu_wr_n,
    input logic [15:0]                cpu_rdata,
    input logic                       cpu_rdata_oe,
    input logic                       wr_even,
    input logic                       wr_odd,
    input logic                       mode_wr,
    input logic [1:0]                 mode_q,
    input logic [(1<<HW_W)*16-1:0]    file_flat
);
    // R10: drive only after a sampled select and read
    p_oe_needs_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata_oe |-> ($past(!cpu_cs_n, 2) && $past(!cpu_rd_n, 2)));

    // R10: quiet bus when not driving
    p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rdata_oe |-> (cpu_rdata == 16'h0000));

    // R7: register file changes only on a write pulse
    p_file_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_even || wr_odd) |=> $stable(file_flat));

    // R9: mode register changes only on its own write
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_q));

    // R8: every commit comes from a selected access
    p_commit_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_even || wr_odd || mode_wr) |-> $past(!cpu_cs_n, 3));

    // R5: byte-enable commits come from the single strobe
    p_be_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && (wr_even || wr_odd || mode_wr)) |-> $past(!cpu_wr_n, 3));

    // R4: dual-strobe commits come from a lane strobe
    p_lane_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[1] && (wr_even || wr_odd || mode_wr))
            |-> ($past(!cpu_wrh_n, 3) || $past(!cpu_wrl_n, 3)));
endmodule

bind cpu_reg_bridge bridge_checker #(.HW_W(HW_W)) u_bridge_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_cs_n     (cpu_cs_n),
    .cpu_rd_n     (cpu_rd_n),
    .cpu_wrh_n    (cpu_wrh_n),
    .cpu_wrl_n    (cpu_wrl_n),
    .cpu_wr_n     (cpu_wr_n),
    .cpu_rdata    (cpu_rdata),
    .cpu_rdata_oe (cpu_rdata_oe),
    .wr_even      (wr_even),
    .wr_odd       (wr_odd),
    .mode_wr      (mode_wr),
    .mode_q       (mode_q),
    .file_flat    (file_flat)
);

// File: tb/tb_cpu_reg_bridge.sv
module tb_cpu_reg_bridge;
    localparam int HW_W   = 4;
    localparam int NUM_HW = 1 << HW_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [HW_W-1:0] cpu_addr = '0;
    logic            cpu_cs_n = 1'b1, cpu_rd_n = 1'b1;
    logic            cpu_wrh_n = 1'b1, cpu_wrl_n = 1'b1, cpu_wr_n = 1'b1;
    logic            cpu_beh_n = 1'b1, cpu_bel_n = 1'b1;
    logic [15:0]     cpu_wdata = '0;
    logic [15:0]     cpu_rdata;
    logic            cpu_rdata_oe;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [7:0] m_even [NUM_HW];
    logic [7:0] m_odd  [NUM_HW];
    logic       m_big = 1'b0;
    logic       m_be  = 1'b0;

    // scoreboard
    typedef struct {
        logic [16:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    logic  mon_go = 1'b0;
    logic  done   = 1'b0;

    always #2.5 clk = ~clk;

    cpu_reg_bridge #(.HW_W(HW_W)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
        .cpu_cs_n(cpu_cs_n), .cpu_rd_n(cpu_rd_n),
        .cpu_wrh_n(cpu_wrh_n), .cpu_wrl_n(cpu_wrl_n), .cpu_wr_n(cpu_wr_n),
        .cpu_beh_n(cpu_beh_n), .cpu_bel_n(cpu_bel_n),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rdata_oe(cpu_rdata_oe)
    );

    function automatic logic [15:0] exp_word(input logic [HW_W-1:0] hw);
        if (hw == '0)   return {14'b0, m_be, m_big};
        else if (m_big) return {m_even[hw], m_odd[hw]};
        else            return {m_odd[hw], m_even[hw]};
    endfunction

    // monitor: pop and compare when the driver flags a due result
    initial begin
        forever begin
            @(negedge clk);
            if (mon_go) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if ({cpu_rdata_oe, cpu_rdata} !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                             it.tag, cpu_rdata_oe, cpu_rdata, it.exp[16], it.exp[15:0]);
                end
                mon_go = 1'b0;
            end
        end
    end

    // read access; with do_rd=0 the read strobe stays high
    task automatic cpu_read(input logic [HW_W-1:0] hw, input bit do_rd, input string tag);
        item_t it;
        @(negedge clk);
        cpu_addr = hw;
        cpu_cs_n = 1'b0;
        cpu_rd_n = !do_rd;
        repeat (4) @(negedge clk);
        it.exp = do_rd ? {1'b1, exp_word(hw)} : 17'h0;
        it.tag = tag;
        sb_q.push_back(it);
        mon_go = 1'b1;
        while (mon_go) @(negedge clk);
        cpu_cs_n = 1'b1;
        cpu_rd_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // write access: ph/pl/pw pulse lane strobes / single strobe; eh/el enables; sel chip select
    task automatic cpu_write(input logic [HW_W-1:0] hw, input logic [15:0] d,
                             input bit ph, input bit pl, input bit pw,
                             input bit eh, input bit el, input bit sel);
        bit hi_go, lo_go;
        @(negedge clk);
        cpu_addr  = hw;
        cpu_wdata = d;
        cpu_cs_n  = !sel;
        cpu_beh_n = !eh;
        cpu_bel_n = !el;
        @(negedge clk);
        cpu_wrh_n = !ph;
        cpu_wrl_n = !pl;
        cpu_wr_n  = !pw;
        repeat (4) @(negedge clk);
        cpu_wrh_n = 1'b1;
        cpu_wrl_n = 1'b1;
        cpu_wr_n  = 1'b1;
        @(negedge clk);
        cpu_cs_n  = 1'b1;
        cpu_beh_n = 1'b1;
        cpu_bel_n = 1'b1;
        repeat (4) @(negedge clk);
        // model update, decoded with the mode in force before the write
        if (m_be) begin hi_go = pw && eh; lo_go = pw && el; end
        else      begin hi_go = ph;       lo_go = pl;       end
        if (!sel) begin hi_go = 0; lo_go = 0; end
        if (hw == '0) begin
            if (lo_go) begin m_big = d[0]; m_be = d[1]; end
        end else if (m_big) begin
            if (hi_go) m_even[hw] = d[15:8];
            if (lo_go) m_odd[hw]  = d[7:0];
        end else begin
            if (lo_go) m_even[hw] = d[7:0];
            if (hi_go) m_odd[hw]  = d[15:8];
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_HW; i++) begin m_even[i] = 8'h00; m_odd[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R10: reset state, idle bus
        cpu_read(4'd0, 1'b1, "R1 mode reg after reset");
        cpu_read(4'd5, 1'b1, "R1 byte regs after reset");
        cpu_read(4'd5, 1'b0, "R10 no read strobe");

        // R2 little-endian, both lane strobes
        cpu_write(4'd3, 16'hA55A, 1, 1, 0, 0, 0, 1);
        cpu_read(4'd3, 1'b1, "R2 little-endian both lanes");
        // R4 single lanes
        cpu_write(4'd4, 16'h1234, 1, 0, 0, 0, 0, 1);
        cpu_read(4'd4, 1'b1, "R4 high strobe only");
        cpu_write(4'd4, 16'hFF56, 0, 1, 0, 0, 0, 1);
        cpu_read(4'd4, 1'b1, "R4 low strobe only");
        // R6 single strobe ignored in dual-strobe mode
        cpu_write(4'd4, 16'hDEAD, 0, 0, 1, 1, 1, 1);
        cpu_read(4'd4, 1'b1, "R6 single strobe ignored");
        // R8 deselected write
        cpu_write(4'd3, 16'h0F0F, 1, 1, 0, 0, 0, 0);
        cpu_read(4'd3, 1'b1, "R8 write without chip select");

        // R9 / R3: switch to big-endian; upper lane of mode reg ignored
        cpu_write(4'd0, 16'hFF01, 1, 1, 0, 0, 0, 1);
        cpu_read(4'd0, 1'b1, "R9 mode reg big-endian");
        cpu_read(4'd3, 1'b1, "R3 big-endian swaps lanes");
        cpu_write(4'd6, 16'hBE00, 1, 0, 0, 0, 0, 1);
        cpu_read(4'd6, 1'b1, "R3 high lane writes even reg");
        // R9 mode reg not written from the high lane
        cpu_write(4'd0, 16'h0300, 1, 0, 0, 0, 0, 1);
        cpu_read(4'd0, 1'b1, "R9 high lane ignored for mode");

        // R11: enter byte-enable mode via lane strobe, then old strobes no longer work
        cpu_write(4'd0, 16'h0003, 0, 1, 0, 0, 0, 1);
        cpu_read(4'd0, 1'b1, "R11 mode now byte-enable");
        cpu_write(4'd7, 16'h1111, 1, 1, 0, 1, 1, 1);
        cpu_read(4'd7, 1'b1, "R6 lane strobes ignored in byte-enable mode");
        // R5 enabled lanes only
        cpu_write(4'd7, 16'hC3D4, 0, 0, 1, 1, 0, 1);
        cpu_read(4'd7, 1'b1, "R5 high enable only");
        cpu_write(4'd7, 16'h00E5, 0, 0, 1, 0, 1, 1);
        cpu_read(4'd7, 1'b1, "R5 low enable only");
        // R7 no enables
        cpu_write(4'd7, 16'h7777, 0, 0, 1, 0, 0, 1);
        cpu_read(4'd7, 1'b1, "R7 no enables no change");

        // R11: back to little-endian dual-strobe via single strobe + low enable
        cpu_write(4'd0, 16'h0000, 0, 0, 1, 0, 1, 1);
        cpu_read(4'd0, 1'b1, "R11 mode back to defaults");
        cpu_write(4'd7, 16'h9988, 1, 1, 0, 0, 0, 1);
        cpu_read(4'd7, 1'b1, "R11 dual strobes active again");
        cpu_read(4'd6, 1'b1, "R2 little-endian view of even reg");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule